// File: doc/BRIEF.md
# Boot-Time Seed Hold Buffer

This block captures the first full window of raw noise after the entropy path is enabled in boot-time mode and holds it as a single seed. While the window is being gathered, separate health-test logic judges the same bits. The held seed is not exposed as valid until that judgement arrives. A passing judgement offers the whole seed at once on a ready/valid output. The seed takes the path that skips the hash conditioner, and a bypass indicator tells downstream logic about this. A failing judgement wipes the held bits and raises a sticky error.

Raw samples are packed in arrival order, with the earliest sample in the lowest bits. The seed is delivered at most once per enable period. After one transfer the block reports that it is finished and ignores its inputs. Dropping the enable returns every register to its reset value, and a new boot-time run can then start.

Top module: `boot_seed_hold`

## Requirements
- R1: After reset, and while `en_i` is low, `seed_valid_o`, `bypass_o`, `fail_o` and `done_o` are 0 and `seed_data_o` is all zeros.
- R2: With `en_i` high and `boot_mode_i` high, the block starts collecting one cycle after it leaves idle. The k-th accepted sample (k counted from 0) is written to `seed_data_o[k*SAMPLE_W +: SAMPLE_W]`, and the result is visible after the clock edge on which `smp_valid_i` is high.
- R3: After SEED_W/SAMPLE_W samples the window is closed. Samples arriving while the verdict is awaited or while the seed is offered do not change `seed_data_o`.
- R4: A verdict counts only after the window has closed. A verdict pulse during collection has no effect. `verdict_valid_i`=1 with `verdict_pass_i`=1 raises `seed_valid_o` on the next cycle.
- R5: While `seed_valid_o`=1 and `seed_ready_i`=0, `seed_valid_o` stays high and `seed_data_o` stays unchanged. The transfer happens on the edge where both are 1.
- R6: `verdict_valid_i`=1 with `verdict_pass_i`=0 raises `fail_o` and clears `seed_data_o` to zero on the next cycle. `seed_valid_o` is never raised afterwards. `fail_o` stays high until `en_i` goes low, even if a passing verdict arrives later.
- R7: After the transfer, `done_o`=1, `seed_valid_o`=0 and `seed_data_o` is zero. Further samples and verdicts are ignored until `en_i` is cleared.
- R8: `bypass_o` is 1 from the first collecting cycle until the transfer, and 0 otherwise.
- R9: With `boot_mode_i` low, the block stays idle and captures nothing.
- R10: Clearing `en_i` in any state returns all outputs to their R1 values after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| en_i | input | 1 | Enable for the entropy path; low clears all state |
| boot_mode_i | input | 1 | Selects boot-time operation |
| smp_valid_i | input | 1 | Raw sample strobe |
| smp_data_i | input | SAMPLE_W | Raw noise sample |
| verdict_valid_i | input | 1 | Health-test window result strobe |
| verdict_pass_i | input | 1 | Result of the health tests: 1 means pass |
| seed_ready_i | input | 1 | Downstream can accept the seed |
| seed_valid_o | output | 1 | Seed offered |
| seed_data_o | output | SEED_W | Held seed |
| bypass_o | output | 1 | The seed path skips the conditioner |
| fail_o | output | 1 | Sticky health-test failure |
| done_o | output | 1 | Seed has been delivered |

## Verification
Every output comes from a register, so each result is due one clock edge after the input that causes it: a sample is visible in the seed after its own edge, and a verdict or handshake changes valid, fail and done after the edge on which it is seen. The only exception is the reset release, which passes through two synchroniser stages. The bench model therefore treats the first two edges after reset release as reset edges. The model advances on each rising edge from the same inputs as the design, and all outputs are compared at the following falling edge. Inputs change only at falling edges, so no comparison races the design.

// File: rtl/boot_seed_hold_pkg.sv
package boot_seed_hold_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_COLLECT = 3'd1,
    ST_WAIT    = 3'd2,
    ST_OFFER   = 3'd3,
    ST_FAIL    = 3'd4
  } bsh_state_e;
endpackage

// File: rtl/bsh_rst_sync.sv
module bsh_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_no = chain_q[STAGES-1];
endmodule

// File: rtl/bsh_seed_store.sv
module bsh_seed_store #(
  parameter int unsigned SAMPLE_W = 4,
  parameter int unsigned NSLOT    = 96,
  parameter int unsigned IDX_W    = 7
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [IDX_W-1:0]          wr_idx_i,
  input  logic [SAMPLE_W-1:0]       wr_data_i,
  input  logic                      clr_i,
  output logic [NSLOT*SAMPLE_W-1:0] seed_o
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    logic [SAMPLE_W-1:0] slot_q;
    logic                slot_we;

    assign slot_we = wr_en_i && (wr_idx_i == IDX_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        slot_q <= '0;
      end else if (clr_i) begin
        slot_q <= '0;
      end else if (slot_we) begin
        slot_q <= wr_data_i;
      end
    end

    assign seed_o[g*SAMPLE_W +: SAMPLE_W] = slot_q;
  end

  AST_WR_IDX_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> (32'(wr_idx_i) < NSLOT)); // R3
endmodule

// File: rtl/bsh_ctrl.sv
module bsh_ctrl
  import boot_seed_hold_pkg::*;
#(
  parameter int unsigned NSLOT = 96,
  parameter int unsigned IDX_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             boot_mode_i,
  input  logic             smp_valid_i,
  input  logic             verdict_valid_i,
  input  logic             verdict_pass_i,
  input  logic             seed_ready_i,
  output logic             wr_en_o,
  output logic [IDX_W-1:0] wr_idx_o,
  output logic             clr_o,
  output logic             seed_valid_o,
  output logic             bypass_o,
  output logic             fail_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LastIdx = IDX_W'(NSLOT - 1);

  bsh_state_e       st_q, st_d;
  logic [IDX_W-1:0] cnt_q, cnt_d;
  logic             done_q, done_d;
  logic             fail_q, fail_d;

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    done_d  = done_q;
    fail_d  = fail_q;
    wr_en_o = 1'b0;
    clr_o   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (boot_mode_i && !done_q) st_d = ST_COLLECT;
      end
      ST_COLLECT: begin
        if (smp_valid_i) begin
          wr_en_o = 1'b1;
          if (cnt_q == LastIdx) begin
            st_d  = ST_WAIT;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_q + IDX_W'(1);
          end
        end
      end
      ST_WAIT: begin
        if (verdict_valid_i) begin
          if (verdict_pass_i) begin
            st_d = ST_OFFER;
          end else begin
            st_d   = ST_FAIL;
            fail_d = 1'b1;
            clr_o  = 1'b1;
          end
        end
      end
      ST_OFFER: begin
        if (seed_ready_i) begin
          st_d   = ST_IDLE;
          done_d = 1'b1;
          clr_o  = 1'b1;
        end
      end
      ST_FAIL: begin
        st_d = ST_FAIL;
      end
      default: st_d = ST_IDLE;
    endcase
    if (!en_i) begin
      st_d    = ST_IDLE;
      cnt_d   = '0;
      done_d  = 1'b0;
      fail_d  = 1'b0;
      wr_en_o = 1'b0;
      clr_o   = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
      fail_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      done_q <= done_d;
      fail_q <= fail_d;
    end
  end

  assign wr_idx_o     = cnt_q;
  assign seed_valid_o = (st_q == ST_OFFER);
  assign bypass_o     = (st_q == ST_COLLECT) || (st_q == ST_WAIT) || (st_q == ST_OFFER);
  assign fail_o       = fail_q;
  assign done_o       = done_q;

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LastIdx); // R3
  AST_VALID_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_valid_o && !seed_ready_i && en_i) |=> (seed_valid_o || !$past(en_i))); // R5
  AST_FAIL_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fail_o && en_i) |=> fail_o); // R6
  AST_FAIL_NO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |-> !seed_valid_o); // R6
  AST_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!seed_valid_o && !fail_o && !bypass_o)); // R7
  AST_DONE_AFTER_XFER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (seed_valid_o && seed_ready_i && en_i) |=> done_o); // R7
endmodule

// File: rtl/boot_seed_hold.sv
module boot_seed_hold #(
  parameter int unsigned SAMPLE_W = 4,
  parameter int unsigned SEED_W   = 384
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                boot_mode_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_data_i,
  input  logic                verdict_valid_i,
  input  logic                verdict_pass_i,
  input  logic                seed_ready_i,
  output logic                seed_valid_o,
  output logic [SEED_W-1:0]   seed_data_o,
  output logic                bypass_o,
  output logic                fail_o,
  output logic                done_o
);
  localparam int unsigned NSLOT = SEED_W / SAMPLE_W;
  localparam int unsigned IDX_W = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic             rst_n_int;
  logic             wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic             clr;

  bsh_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_n_int)
  );

  bsh_ctrl #(.NSLOT(NSLOT), .IDX_W(IDX_W)) u_ctrl (
    .clk_i           (clk_i),
    .rst_ni          (rst_n_int),
    .en_i            (en_i),
    .boot_mode_i     (boot_mode_i),
    .smp_valid_i     (smp_valid_i),
    .verdict_valid_i (verdict_valid_i),
    .verdict_pass_i  (verdict_pass_i),
    .seed_ready_i    (seed_ready_i),
    .wr_en_o         (wr_en),
    .wr_idx_o        (wr_idx),
    .clr_o           (clr),
    .seed_valid_o    (seed_valid_o),
    .bypass_o        (bypass_o),
    .fail_o          (fail_o),
    .done_o          (done_o)
  );

  bsh_seed_store #(.SAMPLE_W(SAMPLE_W), .NSLOT(NSLOT), .IDX_W(IDX_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .wr_en_i   (wr_en),
    .wr_idx_i  (wr_idx),
    .wr_data_i (smp_data_i),
    .clr_i     (clr),
    .seed_o    (seed_data_o)
  );

  AST_DATA_STABLE: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (seed_valid_o && !seed_ready_i && en_i) |=> ($stable(seed_data_o) || !$past(en_i))); // R5
  AST_FAIL_ZERO: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    fail_o |-> (seed_data_o == '0)); // R6
  AST_DISABLE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !en_i |=> (!seed_valid_o && !bypass_o && !fail_o && !done_o && seed_data_o == '0)); // R10
endmodule

// File: tb/tb_boot_seed_hold.sv
`timescale 1ns/1ps
module tb_boot_seed_hold;
  localparam int W  = 4;
  localparam int SW = 384;
  localparam int NS = SW / W;

  logic clk = 1'b0;
  logic rst_n, en, mode, sv, vv, vp, rdy;
  logic [W-1:0]  sd;
  logic          seed_valid, bypass, fail, done;
  logic [SW-1:0] seed;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  string tag = "R1";

  always #4 clk = ~clk; // 125 MHz

  boot_seed_hold #(.SAMPLE_W(W), .SEED_W(SW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .boot_mode_i(mode),
    .smp_valid_i(sv), .smp_data_i(sd), .verdict_valid_i(vv),
    .verdict_pass_i(vp), .seed_ready_i(rdy), .seed_valid_o(seed_valid),
    .seed_data_o(seed), .bypass_o(bypass), .fail_o(fail), .done_o(done)
  );

  // behavioural reference: 0 idle, 1 gather, 2 await, 3 offer, 4 failed
  int            m_st = 0;
  int            m_n = 0;
  int            m_rel = 0;
  bit            m_done = 0, m_fail = 0;
  logic [SW-1:0] m_seed = '0;

  always @(posedge clk) begin
    cyc++;
    if (!rst_n || m_rel < 2 || !en) begin
      if (!rst_n) m_rel = 0; else if (m_rel < 2) m_rel++;
      m_st = 0; m_n = 0; m_done = 0; m_fail = 0; m_seed = '0;
    end else begin
      case (m_st)
        0: if (mode && !m_done) m_st = 1;
        1: if (sv) begin
             m_seed[m_n*W +: W] = sd;
             m_n++;
             if (m_n == NS) begin m_st = 2; m_n = 0; end
           end
        2: if (vv) begin
             if (vp) m_st = 3;
             else begin m_st = 4; m_fail = 1; m_seed = '0; end
           end
        3: if (rdy) begin m_st = 0; m_done = 1; m_seed = '0; end
        default: ;
      endcase
    end
  end

  task automatic cmp(input string rq, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s (phase %s) act=%h exp=%h", rq, tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      cmp("R2", seed, m_seed);
      cmp("R4", SW'(seed_valid), SW'(m_st == 3));
      cmp("R6", SW'(fail), SW'(m_fail));
      cmp("R7", SW'(done), SW'(m_done));
      cmp("R8", SW'(bypass), SW'(m_st >= 1 && m_st <= 3));
    end
    if (cyc > 50000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic push(input logic [W-1:0] d);
    @(negedge clk); sv = 1'b1; sd = d;
    @(negedge clk); sv = 1'b0;
  endtask

  task automatic verdict(input logic p);
    @(negedge clk); vv = 1'b1; vp = p;
    @(negedge clk); vv = 1'b0;
  endtask

  task automatic fill(output logic [SW-1:0] ex);
    ex = '0;
    for (int k = 0; k < NS; k++) begin
      logic [W-1:0] d;
      d = W'($urandom);
      ex[k*W +: W] = d;
      push(d);
      if (k % 7 == 3) @(negedge clk);
    end
  endtask

  logic [SW-1:0] ex;

  initial begin
    rst_n = 0; en = 0; mode = 0; sv = 0; vv = 0; vp = 0; rdy = 0; sd = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    tag = "R1";
    cmp("R1", seed, '0); cmp("R1", SW'({seed_valid, bypass, fail, done}), '0);

    tag = "R9"; en = 1; mode = 0;
    for (int i = 0; i < 10; i++) push(W'(i + 1));
    cmp("R9", seed, '0); cmp("R9", SW'(bypass), '0);

    @(negedge clk); en = 0; @(negedge clk);
    tag = "R2"; en = 1; mode = 1;
    @(negedge clk);
    fill(ex);
    cmp("R2", seed, ex);
    tag = "R3";
    for (int i = 0; i < 5; i++) push(W'(i + 9));
    cmp("R3", seed, ex);
    tag = "R4"; verdict(1'b1);
    cmp("R4", SW'(seed_valid), SW'(1));
    tag = "R5";
    push(W'(5));
    repeat (4) @(negedge clk);
    cmp("R5", SW'(seed_valid), SW'(1)); cmp("R5", seed, ex);
    rdy = 1; @(negedge clk); rdy = 0;
    tag = "R7";
    cmp("R7", SW'(done), SW'(1)); cmp("R7", seed, '0);
    push(W'(3)); verdict(1'b1);
    cmp("R7", SW'({seed_valid, bypass}), '0);

    tag = "R6"; en = 0; @(negedge clk); en = 1; @(negedge clk);
    for (int i = 0; i < 10; i++) push(W'(i));
    verdict(1'b0);
    cmp("R4", SW'(fail), '0);
    fill(ex);
    verdict(1'b0);
    cmp("R6", SW'(fail), SW'(1)); cmp("R6", seed, '0);
    verdict(1'b1); rdy = 1; repeat (3) @(negedge clk); rdy = 0;
    cmp("R6", SW'({seed_valid, fail}), SW'(1));

    tag = "R10"; en = 0; @(negedge clk); en = 1; @(negedge clk);
    for (int i = 0; i < 20; i++) push(W'(i + 2));
    en = 0; @(negedge clk);
    cmp("R10", seed, '0); cmp("R10", SW'({seed_valid, bypass, fail, done}), '0);
    repeat (3) @(negedge clk);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule